// File: doc/BRIEF.md
# Pairwise Add-Accumulate-Long Vector Unit

This unit takes one 32-bit vector instruction word together with a 128-bit source operand and a 128-bit accumulator operand. It decodes the word and runs a widening pairwise accumulate. Each pair of neighbouring source elements is widened and the two are summed. That sum is then added to the accumulator lane of twice the element width that sits at the same position. The old lane value stays part of the result.

The instruction word selects three things at run time: the element width (8, 16 or 32 bits), sign or zero extension, and a 64-bit or 128-bit vector. The unit also returns the decoded 5-bit destination and source register indices, so the surrounding pipeline can write the result back. A word that does not decode raises an undefined flag in place of a valid result. Everything is registered and appears one clock after the input strobe.

Top module: `pwacc_unit`

## Requirements
- R1: Bits 31..23 must be all ones, bits 21..20 ones, bits 17..16 zeros, bits 11..8 equal 0110 and bit 4 zero. If any of these differs, a strobed word gives `undef_q`=1 and `vld_q`=0.
- R2: A size field (bits 19..18) of 11 gives `undef_q`=1 and `vld_q`=0.
- R3: When Q (bit 6) is 1, an odd destination index or an odd source index gives `undef_q`=1 and `vld_q`=0.
- R4: `dst_idx_q` is {bit 22, bits 15..12} and `src_idx_q` is {bit 5, bits 3..0}.
- R5: With size 00, each 16-bit result lane k holds accumulator lane k plus the widened source bytes 2k and 2k+1.
- R6: With size 01, each 32-bit result lane holds its accumulator lane plus the two widened 16-bit source elements below it.
- R7: With size 10, each 64-bit result lane holds its accumulator lane plus the two widened 32-bit source elements below it.
- R8: Bit 7 clear sign-extends the source elements. Bit 7 set zero-extends them.
- R9: With Q (bit 6) clear, only operand bits 63..0 take part and result bits 127..64 are zero.
- R10: Lane sums wrap modulo the lane width, with no saturation.
- R11: The result and flags appear one clock after `in_vld`. A cycle with no strobe leaves `vld_q` and `undef_q` low on the next cycle.
- R12: An active-low synchronous reset clears `vld_q` and `undef_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation strobe |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| in_acc | input | 128 | Accumulator vector |
| res_q | output | 128 | Accumulated result |
| dst_idx_q | output | 5 | Decoded destination register index |
| src_idx_q | output | 5 | Decoded source register index |
| vld_q | output | 1 | Result valid |
| undef_q | output | 1 | Undefined instruction flag |

## Verification
Every output of this unit is due exactly one rising edge after the cycle in which `in_vld` is presented. This covers the result vector, both indices, the valid flag and the undefined flag. Each scenario task drives its operands on a falling edge and drops the strobe on the next falling edge. It reads all outputs at that point, which is half a period after the single register stage has loaded. Idle and reset checks sample on a falling edge in the same way, so the flags they see come from the edge just before.

// File: rtl/pwacc_pkg.sv
package pwacc_pkg;
    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;
    localparam logic [INSN_W-1:0] FIX_MASK  = 32'hFFB3_0F10;
    localparam logic [INSN_W-1:0] FIX_VALUE = 32'hFFB0_0600;

    typedef enum logic [1:0] {
        ESZ_8   = 2'b00,
        ESZ_16  = 2'b01,
        ESZ_32  = 2'b10,
        ESZ_BAD = 2'b11
    } esz_e;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
        esz_e             esz;
        logic             sgn;
        logic             quad;
        logic             illegal;
    } dec_t;
endpackage

// File: rtl/pwacc_decode.sv
module pwacc_decode
    import pwacc_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic fixed_ok;
    logic odd_reg;

    always_comb begin
        fixed_ok     = ((insn & FIX_MASK) == FIX_VALUE);
        dec.dst      = {insn[22], insn[15:12]};
        dec.src      = {insn[5], insn[3:0]};
        dec.esz      = esz_e'(insn[19:18]);
        dec.sgn      = ~insn[7];
        dec.quad     = insn[6];
        odd_reg      = dec.dst[0] | dec.src[0];
        dec.illegal  = ~fixed_ok | (dec.esz == ESZ_BAD) | (dec.quad & odd_reg);
    end
endmodule

// File: rtl/pwacc_lanes.sv
module pwacc_lanes #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] acc,
    input  logic             sgn,
    output logic [VEC_W-1:0] sum
);
    localparam int LANE_W = 2 * ELEM_W;
    localparam int N_LANE = VEC_W / LANE_W;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        logic [ELEM_W-1:0] lo_e, hi_e;
        logic [LANE_W-1:0] lo_x, hi_x;
        assign lo_e = src[g*LANE_W +: ELEM_W];
        assign hi_e = src[g*LANE_W+ELEM_W +: ELEM_W];
        assign lo_x = {{ELEM_W{sgn & lo_e[ELEM_W-1]}}, lo_e};
        assign hi_x = {{ELEM_W{sgn & hi_e[ELEM_W-1]}}, hi_e};
        assign sum[g*LANE_W +: LANE_W] = acc[g*LANE_W +: LANE_W] + lo_x + hi_x;
    end
endmodule

// File: rtl/pwacc_unit.sv
module pwacc_unit
    import pwacc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [VEC_W-1:0]  in_src,
    input  logic [VEC_W-1:0]  in_acc,
    output logic [VEC_W-1:0]  res_q,
    output logic [IDX_W-1:0]  dst_idx_q,
    output logic [IDX_W-1:0]  src_idx_q,
    output logic              vld_q,
    output logic              undef_q
);
    localparam int HALF_W = VEC_W / 2;
    localparam int N_ESZ  = 3;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
        logic             vld;
        logic             undef;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [VEC_W-1:0] src_m, acc_m;
    logic [VEC_W-1:0] sum_by_esz [N_ESZ];
    logic [VEC_W-1:0] sum_sel;

    pwacc_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    assign src_m = dec.quad ? in_src : {{HALF_W{1'b0}}, in_src[HALF_W-1:0]};
    assign acc_m = dec.quad ? in_acc : {{HALF_W{1'b0}}, in_acc[HALF_W-1:0]};

    for (genvar gi = 0; gi < N_ESZ; gi++) begin : g_esz
        pwacc_lanes #(
            .VEC_W  (VEC_W),
            .ELEM_W (8 << gi)
        ) u_lanes (
            .src (src_m),
            .acc (acc_m),
            .sgn (dec.sgn),
            .sum (sum_by_esz[gi])
        );
    end

    always_comb begin
        unique case (dec.esz)
            ESZ_8:   sum_sel = sum_by_esz[0];
            ESZ_16:  sum_sel = sum_by_esz[1];
            ESZ_32:  sum_sel = sum_by_esz[2];
            default: sum_sel = '0;
        endcase
        if (!dec.quad) begin
            sum_sel[VEC_W-1:HALF_W] = '0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.undef = 1'b0;
        if (in_vld) begin
            st_d.dst   = dec.dst;
            st_d.src   = dec.src;
            st_d.vld   = ~dec.illegal;
            st_d.undef = dec.illegal;
            st_d.res   = dec.illegal ? '0 : sum_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q     = st_q.res;
    assign dst_idx_q = st_q.dst;
    assign src_idx_q = st_q.src;
    assign vld_q     = st_q.vld;
    assign undef_q   = st_q.undef;

    AST_VLD_UNDEF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q && undef_q)); // R1
    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_insn[19:18] == 2'b11) |=> (undef_q && !vld_q)); // R2
    AST_QUAD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_insn[6] && (in_insn[12] || in_insn[0])) |=> undef_q); // R3
    AST_DW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_insn[6]) |=> (res_q[VEC_W-1:HALF_W] == '0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!vld_q && !undef_q)); // R11
    AST_VLD_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_q) |-> $past(in_vld)); // R11
endmodule

// File: tb/tb_pwacc_unit.sv
module tb_pwacc_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_src = '0;
    logic [127:0] in_acc = '0;
    logic [127:0] res_q;
    logic [4:0]   dst_idx_q, src_idx_q;
    logic         vld_q, undef_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwacc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_insn(in_insn),
        .in_src(in_src), .in_acc(in_acc), .res_q(res_q),
        .dst_idx_q(dst_idx_q), .src_idx_q(src_idx_q),
        .vld_q(vld_q), .undef_q(undef_q)
    );

    function automatic logic [31:0] mk(input logic d, input logic [3:0] vd,
                                       input logic m, input logic [3:0] vm,
                                       input logic [1:0] sz, input logic op,
                                       input logic q);
        return {9'h1FF, d, 2'b11, sz, 2'b00, vd, 4'b0110, op, q, m, 1'b0, vm};
    endfunction

    function automatic logic [127:0] model(input logic [31:0] w,
                                           input logic [127:0] s,
                                           input logic [127:0] a);
        int esz = 8 << w[19:18];
        int lw  = 2 * esz;
        int nl  = (w[6] ? 128 : 64) / lw;
        logic [127:0] emask = (128'd1 << esz) - 1;
        logic [127:0] lmask = (128'd1 << lw) - 1;
        logic [127:0] r = '0;
        for (int i = 0; i < nl; i++) begin
            logic [127:0] e0, e1, ln;
            e0 = (s >> (i*lw)) & emask;
            e1 = (s >> (i*lw + esz)) & emask;
            if (!w[7]) begin
                if (e0[esz-1]) e0 = e0 | ~emask;
                if (e1[esz-1]) e1 = e1 | ~emask;
            end
            ln = (((a >> (i*lw)) & lmask) + e0 + e1) & lmask;
            r = r | (ln << (i*lw));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] s, input logic [127:0] a);
        @(negedge clk);
        in_vld = 1'b1; in_insn = w; in_src = s; in_acc = a;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R12 vld in reset", {127'd0, vld_q}, 128'd0);
        check("R12 undef in reset", {127'd0, undef_q}, 128'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_byte();
        logic [127:0] s = 128'h0123_89AB_7F80_0102_FEDC_BA98_7654_FFFF;
        logic [127:0] a = 128'h1111_2222_3333_4444_5555_6666_7777_0005;
        logic [31:0] w = mk(1'b1, 4'hA, 1'b0, 4'h4, 2'b00, 1'b0, 1'b1);
        issue(w, s, a);
        check("R5 s8 quad", res_q, model(w, s, a));
        check("R8 s8 lane0 signed", {112'd0, res_q[15:0]}, 128'h0003);
        check("R4 dst index", {123'd0, dst_idx_q}, 128'h1A);
        check("R4 src index", {123'd0, src_idx_q}, 128'h04);
        check("R11 vld one clock later", {127'd0, vld_q}, 128'd1);
        w = mk(1'b0, 4'h2, 1'b1, 4'h6, 2'b00, 1'b1, 1'b1);
        issue(w, s, a);
        check("R8 u8 quad", res_q, model(w, s, a));
        check("R8 u8 lane0 unsigned", {112'd0, res_q[15:0]}, 128'h0203);
    endtask

    task automatic t_half();
        logic [127:0] s = 128'h8000_7FFF_FFFF_0001_1234_ABCD_8001_8001;
        logic [127:0] a = 128'h0000_0001_FFFF_0000_0BAD_F00D_0000_0000;
        logic [31:0] w = mk(1'b0, 4'h0, 1'b0, 4'h2, 2'b01, 1'b0, 1'b1);
        issue(w, s, a);
        check("R6 s16 quad", res_q, model(w, s, a));
        check("R6 s16 lane0", {96'd0, res_q[31:0]}, 128'hFFFF_0002);
        w = mk(1'b0, 4'h0, 1'b0, 4'h2, 2'b01, 1'b1, 1'b1);
        issue(w, s, a);
        check("R6 u16 quad", res_q, model(w, s, a));
    endtask

    task automatic t_word();
        logic [127:0] s = 128'h8000_0000_8000_0000_0000_0003_FFFF_FFFE;
        logic [127:0] a = 128'h0000_0000_0000_0010_0000_0000_0000_0000;
        logic [31:0] w = mk(1'b1, 4'h8, 1'b1, 4'hE, 2'b10, 1'b0, 1'b1);
        issue(w, s, a);
        check("R7 s32 quad", res_q, model(w, s, a));
        check("R7 s32 lane0", {64'd0, res_q[63:0]}, 128'h1);
        check("R7 s32 lane1", {64'd0, res_q[127:64]}, 128'hFFFF_FFFF_0000_0010);
    endtask

    task automatic t_wrap();
        logic [127:0] s = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        logic [127:0] a = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        logic [31:0] w = mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b10, 1'b1, 1'b1);
        issue(w, s, a);
        check("R10 u32 wrap", {64'd0, res_q[63:0]}, 128'h1_FFFF_FFFD);
        w = mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b00, 1'b1, 1'b1);
        s = 128'hFF; a = 128'hFFFF;
        issue(w, s, a);
        check("R10 u8 wrap", {112'd0, res_q[15:0]}, 128'h00FE);
    endtask

    task automatic t_dword();
        logic [127:0] s = 128'hDEAD_BEEF_CAFE_F00D_8001_7FFF_0102_0304;
        logic [127:0] a = 128'h5555_5555_5555_5555_0000_0001_0000_0002;
        logic [31:0] w = mk(1'b0, 4'h3, 1'b0, 4'h7, 2'b01, 1'b1, 1'b0);
        issue(w, s, a);
        check("R9 dw upper zero", {64'd0, res_q[127:64]}, 128'd0);
        check("R9 dw low lanes", res_q, model(w, s, a));
        check("R4 odd index ok in dw", {127'd0, vld_q}, 128'd1);
    endtask

    task automatic t_illegal();
        logic [31:0] w = mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b11, 1'b0, 1'b1);
        issue(w, 128'h1, 128'h1);
        check("R2 size 11 undef", {126'd0, undef_q, vld_q}, 128'b10);
        w = mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b00, 1'b0, 1'b1) | 32'h10;
        issue(w, 128'h1, 128'h1);
        check("R1 bit4 set undef", {126'd0, undef_q, vld_q}, 128'b10);
        w = mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b00, 1'b0, 1'b1) & ~32'h8000_0000;
        issue(w, 128'h1, 128'h1);
        check("R1 bit31 clear undef", {126'd0, undef_q, vld_q}, 128'b10);
        w = mk(1'b0, 4'h3, 1'b0, 4'h0, 2'b00, 1'b0, 1'b1);
        issue(w, 128'h1, 128'h1);
        check("R3 odd dst quad", {126'd0, undef_q, vld_q}, 128'b10);
        w = mk(1'b0, 4'h0, 1'b0, 4'h5, 2'b01, 1'b0, 1'b1);
        issue(w, 128'h1, 128'h1);
        check("R3 odd src quad", {126'd0, undef_q, vld_q}, 128'b10);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R11 idle no flags", {126'd0, undef_q, vld_q}, 128'b00);
        issue(mk(1'b0, 4'h0, 1'b0, 4'h0, 2'b00, 1'b0, 1'b1), 128'h0, 128'h0);
        check("R11 strobe gives vld", {127'd0, vld_q}, 128'd1);
        @(negedge clk);
        check("R11 vld drops", {127'd0, vld_q}, 128'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_byte();
        t_half();
        t_word();
        t_wrap();
        t_dword();
        t_illegal();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule